// File: doc/BRIEF.md
# Fetch Thread Selector

The block chooses which hardware thread may fetch instructions on a given request. It is used in a multi-threaded front end. Each fetch slot raises `req_i` and gets back a thread ID, or no thread. The choice depends on four inputs:

- a policy code;
- the number of configured threads;
- a mask of active threads;
- a per-thread fetch state and a per-thread issue-queue occupancy.

Fetch slots that share a cycle are served as successive requests. Each granted round-robin request updates the order.

Fairness under round-robin comes from an ordered priority list. The list holds every thread ID once. A request walks the list from its head, takes the first eligible thread and moves that thread to the tail. Threads behind it each move up one place. The queue-count policy favours the thread with the least issue-queue occupancy. A single-thread policy always names thread 0. When only one thread is configured, the first active thread is used, if it can fetch.

Top module: `fetch_thread_sel`

## Requirements
- R1: A thread is eligible only when its `active_i` bit is set and its 3-bit state is 0 (running), 1 (idle) or 5 (cache access done). States 2 (squashing), 3 (blocked), 4 (waiting on cache), 6 and 7 are never eligible.
- R2: When `thread_cnt_i` is 1, whatever the policy, the lowest-numbered active thread is returned if it is eligible; otherwise `valid_o` is 0.
- R3: With policy code 0 (single thread) and more than one thread configured, a request returns valid with thread 0, whatever the thread states.
- R4: With policy code 1 (round-robin), the selected thread is the first eligible thread found when walking the priority list from its head.
- R5: A granted round-robin request moves the selected thread to the tail of the list and shifts the threads that were behind it up one place. Requests under other policies, and requests that are refused, leave the list unchanged.
- R6: After reset the priority list holds the thread IDs in ascending order, head first.
- R7: With policy code 2 (queue count), the eligible thread with the smallest occupancy is selected, and a tie goes to the lower thread ID.
- R8: Policy code 3 selects nothing when more than one thread is configured.
- R9: With more than one thread configured, a thread whose ID is not below `thread_cnt_i` is never selected by policies 1 and 2.
- R10: `valid_o` is 0 when `req_i` is low or when no thread qualifies. Neither case changes the priority list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Selection request for one fetch slot |
| policy_i | input | 2 | Policy: 0 single, 1 round-robin, 2 queue count, 3 invalid |
| thread_cnt_i | input | 3 | Number of configured threads |
| active_i | input | 4 | Active-thread mask |
| state_i | input | 12 | Per-thread 3-bit fetch state, thread i at bits 3i+2:3i |
| occ_i | input | 24 | Per-thread 6-bit queue occupancy, thread i at bits 6i+5:6i |
| valid_o | output | 1 | A thread was selected |
| tid_o | output | 2 | Selected thread ID |

## Verification
Round-robin is the only policy with memory, so a corrupted priority list can show up only there. A wrong order, a lost ID or a duplicated ID appears as a wrong `tid_o` on the next granted round-robin request, one clock after the faulty update. Some corruption shows only when certain threads are blocked. For that reason the bench interleaves blocked threads, refused requests and requests under other policies with round-robin grants, and compares the full sequence of IDs. The stateless policies are checked on the same cycle in which their inputs are applied.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [2:0] {
    ST_RUN     = 3'd0,
    ST_IDLE    = 3'd1,
    ST_SQUASH  = 3'd2,
    ST_BLOCKED = 3'd3,
    ST_IC_WAIT = 3'd4,
    ST_IC_DONE = 3'd5,
    ST_OFF     = 3'd6,
    ST_RSVD    = 3'd7
  } fstate_e;

  typedef enum logic [1:0] {
    POL_SINGLE = 2'd0,
    POL_RR     = 2'd1,
    POL_QCNT   = 2'd2,
    POL_BAD    = 2'd3
  } policy_e;

  localparam int unsigned ST_W = 3;
endpackage

// File: rtl/fts_elig.sv
module fts_elig import fts_pkg::*; #(
  parameter int unsigned NUM_THREADS = 4
) (
  input  logic [NUM_THREADS-1:0]      active_i,
  input  logic [NUM_THREADS*ST_W-1:0] state_i,
  output logic [NUM_THREADS-1:0]      elig_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    fstate_e st;
    assign st = fstate_e'(state_i[t*ST_W +: ST_W]);
    assign elig_o[t] = active_i[t] &&
                       (st == ST_RUN || st == ST_IDLE || st == ST_IC_DONE);
  end
endmodule

// File: rtl/fts_min_occ.sv
module fts_min_occ #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned CNT_W       = 6,
  localparam int unsigned TID_W      = $clog2(NUM_THREADS)
) (
  input  logic [NUM_THREADS-1:0]       elig_i,
  input  logic [NUM_THREADS*CNT_W-1:0] occ_i,
  output logic                         valid_o,
  output logic [TID_W-1:0]             tid_o
);
  logic [CNT_W-1:0] best;

  // Ascending scan with strict compare keeps the lower ID on ties.
  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    best    = '1;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (elig_i[t] && (!valid_o || occ_i[t*CNT_W +: CNT_W] < best)) begin
        valid_o = 1'b1;
        tid_o   = TID_W'(t);
        best    = occ_i[t*CNT_W +: CNT_W];
      end
    end
  end

  always_comb begin
    if (valid_o) begin
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (elig_i[t]) begin
          assert_min_occ_R7: assert (occ_i[t*CNT_W +: CNT_W] >
                                     occ_i[tid_o*CNT_W +: CNT_W] ||
                                     (occ_i[t*CNT_W +: CNT_W] ==
                                      occ_i[tid_o*CNT_W +: CNT_W] && t >= int'(tid_o)));
        end
      end
    end
  end
endmodule

// File: rtl/fts_rr_list.sv
module fts_rr_list #(
  parameter int unsigned NUM_THREADS = 4,
  localparam int unsigned TID_W      = $clog2(NUM_THREADS)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_THREADS-1:0] elig_i,
  input  logic                   grant_i,
  output logic                   valid_o,
  output logic [TID_W-1:0]       tid_o
);
  logic [NUM_THREADS-1:0][TID_W-1:0] prio_q, prio_d;
  logic [TID_W-1:0] pos;

  always_comb begin
    valid_o = 1'b0;
    pos     = '0;
    for (int p = 0; p < NUM_THREADS; p++) begin
      if (!valid_o && elig_i[prio_q[p]]) begin
        valid_o = 1'b1;
        pos     = TID_W'(p);
      end
    end
    tid_o = prio_q[pos];
  end

  always_comb begin
    for (int p = 0; p < NUM_THREADS; p++) begin
      if (p < int'(pos)) prio_d[p] = prio_q[p];
      else               prio_d[p] = prio_q[(p + 1) % NUM_THREADS];
    end
    prio_d[NUM_THREADS-1] = prio_q[pos];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_THREADS; p++) prio_q[p] <= TID_W'(p);
    end else if (grant_i && valid_o) begin
      prio_q <= prio_d;
    end
  end

  logic [NUM_THREADS-1:0] present;
  always_comb begin
    present = '0;
    for (int p = 0; p < NUM_THREADS; p++) present[prio_q[p]] = 1'b1;
  end

  assert_list_perm_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(present) == NUM_THREADS);
  assert_tail_move_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_i && valid_o) |=> prio_q[NUM_THREADS-1] == $past(tid_o));
  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_i && valid_o) |=> $stable(prio_q));
endmodule

// File: rtl/fetch_thread_sel.sv
module fetch_thread_sel import fts_pkg::*; #(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned CNT_W       = 6,
  localparam int unsigned TID_W      = $clog2(NUM_THREADS),
  localparam int unsigned NCNT_W     = $clog2(NUM_THREADS + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic [1:0]                   policy_i,
  input  logic [NCNT_W-1:0]            thread_cnt_i,
  input  logic [NUM_THREADS-1:0]       active_i,
  input  logic [NUM_THREADS*ST_W-1:0]  state_i,
  input  logic [NUM_THREADS*CNT_W-1:0] occ_i,
  output logic                         valid_o,
  output logic [TID_W-1:0]             tid_o
);
  logic [NUM_THREADS-1:0] elig_base, elig_cfg;
  logic                   rr_valid, qc_valid, one_valid;
  logic [TID_W-1:0]       rr_tid, qc_tid, one_tid;
  logic                   single_cfg;
  policy_e                pol;

  assign pol        = policy_e'(policy_i);
  assign single_cfg = (thread_cnt_i == NCNT_W'(1));

  fts_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .active_i (active_i),
    .state_i  (state_i),
    .elig_o   (elig_base)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cfg
    assign elig_cfg[t] = elig_base[t] && (t < int'(thread_cnt_i));
  end

  // Lowest active thread, taken only if it can fetch.
  always_comb begin
    one_tid = '0;
    for (int t = NUM_THREADS - 1; t >= 0; t--) begin
      if (active_i[t]) one_tid = TID_W'(t);
    end
    one_valid = |active_i && elig_base[one_tid];
  end

  fts_rr_list #(.NUM_THREADS(NUM_THREADS)) u_rr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .elig_i  (elig_cfg),
    .grant_i (req_i && !single_cfg && pol == POL_RR),
    .valid_o (rr_valid),
    .tid_o   (rr_tid)
  );

  fts_min_occ #(.NUM_THREADS(NUM_THREADS), .CNT_W(CNT_W)) u_qc (
    .elig_i  (elig_cfg),
    .occ_i   (occ_i),
    .valid_o (qc_valid),
    .tid_o   (qc_tid)
  );

  always_comb begin
    valid_o = 1'b0;
    tid_o   = '0;
    if (single_cfg) begin
      valid_o = one_valid;
      tid_o   = one_tid;
    end else begin
      unique case (pol)
        POL_SINGLE: begin valid_o = 1'b1;     tid_o = '0;     end
        POL_RR:     begin valid_o = rr_valid; tid_o = rr_tid; end
        POL_QCNT:   begin valid_o = qc_valid; tid_o = qc_tid; end
        default:    begin valid_o = 1'b0;     tid_o = '0;     end
      endcase
    end
    if (!req_i) valid_o = 1'b0;
  end

  assert_sel_elig_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && (single_cfg || pol != POL_SINGLE)) |-> elig_base[tid_o]);
  assert_bad_pol_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!single_cfg && pol == POL_BAD) |-> !valid_o);
  assert_cnt_limit_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !single_cfg && pol != POL_SINGLE) |-> int'(tid_o) < int'(thread_cnt_i));
endmodule

// File: tb/fetch_thread_sel_test.sv
module fetch_thread_sel_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [1:0]  pol = 2'd0;
  logic [2:0]  cnt = 3'd4;
  logic [3:0]  act = 4'hF;
  logic [11:0] st  = '0;
  logic [23:0] occ = '0;
  logic        valid;
  logic [1:0]  tid;
  int          n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  fetch_thread_sel uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .policy_i(pol),
    .thread_cnt_i(cnt), .active_i(act), .state_i(st), .occ_i(occ),
    .valid_o(valid), .tid_o(tid)
  );

  typedef struct packed {
    logic [1:0]  pol;
    logic [2:0]  cnt;
    logic [3:0]  act;
    logic [11:0] st;
    logic [23:0] occ;
    logic        ev;
    logic [1:0]  et;
  } vec_t;

  // state {t3,t2,t1,t0}: 0 run, 1 idle, 2 squash, 3 blocked, 4 wait, 5 done
  localparam vec_t VEC [12] = '{
    '{2'd0, 3'd4, 4'hF, {3'd3,3'd3,3'd3,3'd3}, 24'd0,                      1'b1, 2'd0}, // R3
    '{2'd2, 3'd4, 4'hF, 12'd0, {6'd5,6'd2,6'd9,6'd7},                      1'b1, 2'd2}, // R7
    '{2'd2, 3'd4, 4'hF, 12'd0, {6'd3,6'd9,6'd3,6'd8},                      1'b1, 2'd1}, // R7 tie
    '{2'd2, 3'd4, 4'hF, {3'd0,3'd0,3'd0,3'd2}, {6'd4,6'd6,6'd4,6'd1},      1'b1, 2'd1}, // R1 squash
    '{2'd2, 3'd4, 4'b1011, 12'd0, {6'd6,6'd0,6'd7,6'd5},                   1'b1, 2'd0}, // R1 inactive
    '{2'd2, 3'd4, 4'hF, {3'd7,3'd2,3'd3,3'd4}, 24'd0,                      1'b0, 2'd0}, // R10 none
    '{2'd3, 3'd4, 4'hF, 12'd0, 24'd0,                                      1'b0, 2'd0}, // R8
    '{2'd2, 3'd1, 4'b0110, {3'd0,3'd0,3'd5,3'd0}, 24'd0,                   1'b1, 2'd1}, // R2
    '{2'd1, 3'd1, 4'b0110, {3'd0,3'd0,3'd3,3'd0}, 24'd0,                   1'b0, 2'd0}, // R2 blocked
    '{2'd3, 3'd1, 4'b0001, {3'd0,3'd0,3'd0,3'd1}, 24'd0,                   1'b1, 2'd0}, // R2 any policy
    '{2'd2, 3'd2, 4'hF, 12'd0, {6'd0,6'd0,6'd9,6'd8},                      1'b1, 2'd0}, // R9
    '{2'd2, 3'd4, 4'hF, {3'd0,3'd0,3'd5,3'd1}, {6'd5,6'd5,6'd2,6'd2},      1'b1, 2'd0}  // R1 idle/done
  };

  task automatic check(input string tag, input logic ev, input logic [1:0] et);
    n_chk++;
    if (valid !== ev || (ev && tid !== et)) begin
      n_fail++;
      $display("FAIL %s: valid=%0b tid=%0d expected valid=%0b tid=%0d", tag, valid, tid, ev, et);
    end
  endtask

  // Drive after a falling edge, sample before the next rising edge.
  task automatic rr_step(input string tag, input logic r, input logic [11:0] s,
                         input logic ev, input logic [1:0] et);
    @(negedge clk);
    req = r; pol = 2'd1; cnt = 3'd4; act = 4'hF; st = s; occ = '0;
    #2 check(tag, ev, et);
  endtask

  localparam logic [11:0] ALL_RUN = 12'd0;
  localparam logic [11:0] T3_BLK  = {3'd3,3'd0,3'd0,3'd0};
  localparam logic [11:0] ALL_BLK = {3'd3,3'd3,3'd3,3'd3};

  initial begin
    repeat (2000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog: expired, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2 check("R10 reset idle", 1'b0, 2'd0);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      req = 1'b1; pol = VEC[i].pol; cnt = VEC[i].cnt; act = VEC[i].act;
      st = VEC[i].st; occ = VEC[i].occ;
      #2 check($sformatf("vector %0d", i), VEC[i].ev, VEC[i].et);
    end

    // Round-robin list walk; list after each step in comments.
    rr_step("R6 first pick",      1'b1, ALL_RUN, 1'b1, 2'd0); // 1,2,3,0
    rr_step("R4 next",            1'b1, ALL_RUN, 1'b1, 2'd1); // 2,3,0,1
    rr_step("R10 no req",         1'b0, ALL_RUN, 1'b0, 2'd0);
    rr_step("R10 list held",      1'b1, ALL_RUN, 1'b1, 2'd2); // 3,0,1,2
    rr_step("R4 skip blocked",    1'b1, T3_BLK,  1'b1, 2'd0); // 3,1,2,0
    rr_step("R4 skip blocked 2",  1'b1, T3_BLK,  1'b1, 2'd1); // 3,2,0,1
    rr_step("R10 none eligible",  1'b1, ALL_BLK, 1'b0, 2'd0);
    rr_step("R5 blocked stays",   1'b1, ALL_RUN, 1'b1, 2'd3); // 2,0,1,3
    rr_step("R5 order kept",      1'b1, ALL_RUN, 1'b1, 2'd2); // 0,1,3,2
    @(negedge clk);
    req = 1'b1; pol = 2'd2; st = ALL_RUN; occ = '0;
    #2 check("R7 qcnt during rr", 1'b1, 2'd0);
    rr_step("R5 other policy",    1'b1, ALL_RUN, 1'b1, 2'd0); // 1,3,2,0
    rr_step("R5 after rotate",    1'b1, ALL_RUN, 1'b1, 2'd1); // 3,2,0,1

    @(negedge clk); req = 1'b0; rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rr_step("R6 after reset",     1'b1, ALL_RUN, 1'b1, 2'd0);

    @(negedge clk); req = 1'b0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule